// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from a set of sources (sixteen by default) and tells the processor core when to enter a handler and at which address. Each source owns three bits: a sticky request flag, an enable and a priority. Flags are set by single-cycle event pulses on `src_evt` and are cleared only by software through the register port.

A mode bit selects the decision rules. In compatibility mode a single global enable gates every source, a second enable additionally gates the sources marked as peripheral by the `PERIPH_MASK` parameter, and every entry uses vector 0x0008. In priority mode the two enable bits become a high-group and a low-group global enable. High-priority entries use vector 0x0008 and low-priority entries use vector 0x0018. A high handler may preempt a running low handler, but a low request waits while a high handler runs.

On entry the block clears the global enable of the level it entered. The core's return strobe `irq_ret` sets that enable again. The block records whether a high handler nested over a low one, so that after returning from the high handler the low handler is still marked as running. `irq_take` is a single-cycle pulse, and `irq_vector` is valid together with it. These are plain control pins with no handshake, so no back-pressure applies. The register port is a plain write strobe plus a combinational read.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero (compatibility mode, all enables and flags clear, no handler active), `irq_take` is low and `irq_vector` is 0.
- R2: A pulse on `src_evt[i]` sets flag i at the next clock edge. A flag is never cleared by being taken. It is cleared only by a write to address 1, and an event arriving in the same cycle as that write wins for its bit.
- R3: In compatibility mode (address 0 bit 0 = 0), the block enters a handler when bit 1 (global enable) is set and some source has its flag and enable set. Sources whose `PERIPH_MASK` bit is 1 also need bit 2 (peripheral enable). The vector is 0x0008.
- R4: On entering at the high or compatibility level the block clears address 0 bit 1. A return strobe while that handler is active sets the bit again and clears the active marker. These hardware updates override a register write in the same cycle.
- R5: In priority mode (address 0 bit 0 = 1), a source whose priority bit (address 3) is 1 is high and is gated by bit 1. It enters at vector 0x0008 and sets status bit 0 (address 4). A source whose priority bit is 0 is low and is gated by bit 2. It enters at vector 0x0018, sets status bit 1 and clears address 0 bit 2.
- R6: When an eligible high request and an eligible low request exist in the same cycle, the high one is taken.
- R7: An eligible high request preempts an active low handler and sets status bit 2 (nested). No low request is taken while status bit 0 is set, even if bit 2 of address 0 is set.
- R8: A return strobe while a nested high handler is active clears status bits 0 and 2, restores address 0 bit 1, and leaves status bit 1 and address 0 bit 2 unchanged. A following return then clears status bit 1 and sets address 0 bit 2.
- R9: `irq_take` rises in the cycle after the clock edge at which the request became eligible. It lasts one cycle per entry, and `irq_vector` holds the last taken vector. No entry is taken in a cycle where `irq_ret` is high.
- R10: A return strobe while no handler is active changes no register and causes no entry.
- R11: Addresses 2 (enables) and 3 (priorities) read back the last written value. Addresses 5 to 7 read zero. Address 0 uses bits 2:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Write address (0 control, 1 flags, 2 enables, 3 priorities) |
| reg_wr_data | input | NSRC | Write data |
| reg_rd_addr | input | 3 | Read address (adds 4 = status) |
| reg_rd_data | output | NSRC | Combinational read data |
| src_evt | input | NSRC | Per-source event pulses that set flags |
| irq_ret | input | 1 | Return-from-handler strobe from the core |
| irq_take | output | 1 | One-cycle handler-entry pulse |
| irq_vector | output | VEC_W | Entry address, valid with `irq_take` |

## Verification
The bench goes after the cases that break the nesting rules. A simultaneous high and low request must go high; a design that favoured the low one would enter at 0x0018 and later report a bogus nesting. A low request raised with its group enable set during a high handler must stay pending, otherwise the block would re-enter at the low level under a running high handler. A return from a nested high handler must leave the low handler marked active with its enable still clear, otherwise a low source would re-enter its own handler at once. It also covers events that collide with a flag-clearing write, peripheral gating in compatibility mode, and stray return strobes that must change nothing.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Register addresses shared by the write and read paths.
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_FLAG   = 3'd1;
  localparam logic [2:0] ADDR_ENABLE = 3'd2;
  localparam logic [2:0] ADDR_PRIO   = 3'd3;
  localparam logic [2:0] ADDR_STATUS = 3'd4;

  localparam int unsigned VEC_HI = 32'h0008;
  localparam int unsigned VEC_LO = 32'h0018;

  // Control word: bit2 low-group / peripheral enable,
  // bit1 high-group / global enable, bit0 priority mode.
  typedef struct packed {
    logic en_lo;
    logic en_hi;
    logic prio_mode;
  } irq_ctrl_t;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_HI   = 2'd1,
    TAKE_LO   = 2'd2
  } take_kind_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [NSRC-1:0] wr_data,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pri_q
);

  logic wr_flag, wr_en_reg, wr_pri;

  assign wr_flag   = wr_en && (wr_addr == ADDR_FLAG);
  assign wr_en_reg = wr_en && (wr_addr == ADDR_ENABLE);
  assign wr_pri    = wr_en && (wr_addr == ADDR_PRIO);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // Event set wins over a clearing write to the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
        pri_q[i]  <= 1'b0;
      end else begin
        if (evt[i])       flag_q[i] <= 1'b1;
        else if (wr_flag) flag_q[i] <= wr_data[i];
        if (wr_en_reg)    en_q[i]   <= wr_data[i];
        if (wr_pri)       pri_q[i]  <= wr_data[i];
      end
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int              NSRC        = 16,
  parameter logic [NSRC-1:0] PERIPH_MASK = '1
) (
  input  logic [NSRC-1:0] flag_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] pri_q,
  input  irq_ctrl_t       ctrl,
  input  logic            act_hi,
  input  logic            ret,
  output take_kind_e      take_kind
);

  logic [NSRC-1:0] compat_elig;
  logic [NSRC-1:0] hi_elig;
  logic [NSRC-1:0] lo_elig;
  logic            any_compat, any_hi, any_lo;
  logic            hi_go, lo_go, compat_go;

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    logic armed;
    assign armed          = flag_q[i] & en_q[i];
    assign compat_elig[i] = armed & (!PERIPH_MASK[i] | ctrl.en_lo);
    assign hi_elig[i]     = armed &  pri_q[i];
    assign lo_elig[i]     = armed & ~pri_q[i];
  end

  assign any_compat = |compat_elig;
  assign any_hi     = |hi_elig;
  assign any_lo     = |lo_elig;

  // Single global gate in compatibility mode.
  assign compat_go = ctrl.en_hi & any_compat;
  // Priority mode: high wins; low waits for high handlers to finish.
  assign hi_go     = ctrl.en_hi & any_hi;
  assign lo_go     = ctrl.en_lo & any_lo & !act_hi & !hi_go;

  always_comb begin
    take_kind = TAKE_NONE;
    if (!ret) begin
      if (!ctrl.prio_mode) begin
        if (compat_go) take_kind = TAKE_HI;
      end else if (hi_go) begin
        take_kind = TAKE_HI;
      end else if (lo_go) begin
        take_kind = TAKE_LO;
      end
    end
  end

endmodule

// File: rtl/irq_level_state.sv
module irq_level_state
  import irq_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  irq_ctrl_t        wr_ctrl_val,
  input  logic             ret,
  input  take_kind_e       take_kind,
  output irq_ctrl_t        ctrl_q,
  output logic             act_hi_q,
  output logic             act_lo_q,
  output logic             nested_q,
  output logic             take_q,
  output logic [VEC_W-1:0] vec_q
);

  localparam logic [VEC_W-1:0] VHI = VEC_W'(VEC_HI);
  localparam logic [VEC_W-1:0] VLO = VEC_W'(VEC_LO);

  irq_ctrl_t        ctrl_n;
  logic             act_hi_n, act_lo_n, nested_n, take_n;
  logic [VEC_W-1:0] vec_n;

  always_comb begin
    ctrl_n   = ctrl_q;
    act_hi_n = act_hi_q;
    act_lo_n = act_lo_q;
    nested_n = nested_q;
    vec_n    = vec_q;
    take_n   = 1'b0;

    if (wr_ctrl) ctrl_n = wr_ctrl_val;

    // Return: leave the innermost active level.
    if (ret) begin
      if (act_hi_q) begin
        act_hi_n     = 1'b0;
        nested_n     = 1'b0;
        ctrl_n.en_hi = 1'b1;
      end else if (act_lo_q) begin
        act_lo_n     = 1'b0;
        ctrl_n.en_lo = 1'b1;
      end
    end

    unique case (take_kind)
      TAKE_HI: begin
        ctrl_n.en_hi = 1'b0;
        act_hi_n     = 1'b1;
        nested_n     = act_lo_q;
        take_n       = 1'b1;
        vec_n        = VHI;
      end
      TAKE_LO: begin
        ctrl_n.en_lo = 1'b0;
        act_lo_n     = 1'b1;
        take_n       = 1'b1;
        vec_n        = VLO;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      act_hi_q <= 1'b0;
      act_lo_q <= 1'b0;
      nested_q <= 1'b0;
      take_q   <= 1'b0;
      vec_q    <= '0;
    end else begin
      ctrl_q   <= ctrl_n;
      act_hi_q <= act_hi_n;
      act_lo_q <= act_lo_n;
      nested_q <= nested_n;
      take_q   <= take_n;
      vec_q    <= vec_n;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int              NSRC        = 16,
  parameter int              VEC_W       = 16,
  parameter logic [NSRC-1:0] PERIPH_MASK = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_wr_addr,
  input  logic [NSRC-1:0]  reg_wr_data,
  input  logic [2:0]       reg_rd_addr,
  output logic [NSRC-1:0]  reg_rd_data,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             irq_ret,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_vector
);

  localparam int CTRL_W = $bits(irq_ctrl_t);

  logic [NSRC-1:0] flag_q, en_q, pri_q;
  irq_ctrl_t       ctrl_q;
  logic            act_hi_q, act_lo_q, nested_q;
  take_kind_e      take_kind;
  logic            wr_ctrl;

  assign wr_ctrl = reg_wr_en && (reg_wr_addr == ADDR_CTRL);

  irq_flag_bank #(.NSRC(NSRC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .evt     (src_evt),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .pri_q   (pri_q)
  );

  irq_arbiter #(.NSRC(NSRC), .PERIPH_MASK(PERIPH_MASK)) u_arb (
    .flag_q    (flag_q),
    .en_q      (en_q),
    .pri_q     (pri_q),
    .ctrl      (ctrl_q),
    .act_hi    (act_hi_q),
    .ret       (irq_ret),
    .take_kind (take_kind)
  );

  irq_level_state #(.VEC_W(VEC_W)) u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_ctrl_val (irq_ctrl_t'(reg_wr_data[CTRL_W-1:0])),
    .ret         (irq_ret),
    .take_kind   (take_kind),
    .ctrl_q      (ctrl_q),
    .act_hi_q    (act_hi_q),
    .act_lo_q    (act_lo_q),
    .nested_q    (nested_q),
    .take_q      (irq_take),
    .vec_q       (irq_vector)
  );

  always_comb begin
    reg_rd_data = '0;
    unique case (reg_rd_addr)
      ADDR_CTRL:   reg_rd_data[CTRL_W-1:0] = ctrl_q;
      ADDR_FLAG:   reg_rd_data = flag_q;
      ADDR_ENABLE: reg_rd_data = en_q;
      ADDR_PRIO:   reg_rd_data = pri_q;
      ADDR_STATUS: reg_rd_data[2:0] = {nested_q, act_lo_q, act_hi_q};
      default:     reg_rd_data = '0;
    endcase
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [2:0]       reg_wr_addr,
  input logic             irq_ret,
  input logic             irq_take,
  input logic [VEC_W-1:0] irq_vector,
  input logic [NSRC-1:0]  flag_q,
  input irq_ctrl_t        ctrl_q,
  input logic             act_hi_q,
  input logic             act_lo_q,
  input logic             nested_q
);

  localparam logic [VEC_W-1:0] VHI = VEC_W'(VEC_HI);
  localparam logic [VEC_W-1:0] VLO = VEC_W'(VEC_LO);

  logic wr_flag, wr_ctl;
  assign wr_flag = reg_wr_en && (reg_wr_addr == ADDR_FLAG);
  assign wr_ctl  = reg_wr_en && (reg_wr_addr == ADDR_CTRL);

  // R2: flags drop only after a flag write.
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> (($past(flag_q) & ~flag_q) == '0));

  // R3: compatibility-mode entries always use the high vector.
  assert_compat_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !$past(ctrl_q.prio_mode)) |-> (irq_vector == VHI));

  // R4: entering at the high level leaves its enable cleared.
  assert_gie_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vector == VHI) |-> (!ctrl_q.en_hi && act_hi_q));

  // R7: no low entry while a high handler is running.
  assert_low_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi_q |=> !(irq_take && irq_vector == VLO));

  // R8: leaving a nested high handler keeps the low one active.
  assert_nest_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && act_hi_q && nested_q) |=> (act_lo_q && !act_hi_q && !nested_q));

  // R9: a high entry is a single-cycle pulse.
  assert_take_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_vector == VHI) |=> !irq_take);

  // R9: no entry right after a return strobe cycle.
  assert_no_take_on_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret |=> !irq_take);

  // R10: a stray return leaves the control word alone.
  assert_ret_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !act_hi_q && !act_lo_q && !wr_ctl) |=> $stable(ctrl_q));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_addr (reg_wr_addr),
  .irq_ret     (irq_ret),
  .irq_take    (irq_take),
  .irq_vector  (irq_vector),
  .flag_q      (flag_q),
  .ctrl_q      (ctrl_q),
  .act_hi_q    (act_hi_q),
  .act_lo_q    (act_lo_q),
  .nested_q    (nested_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 16;
  localparam int VEC_W = 16;
  localparam logic [NSRC-1:0] PMASK = 16'hFFF0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [2:0]       reg_wr_addr = '0;
  logic [NSRC-1:0]  reg_wr_data = '0;
  logic [2:0]       reg_rd_addr = '0;
  logic [NSRC-1:0]  reg_rd_data;
  logic [NSRC-1:0]  src_evt = '0;
  logic             irq_ret = 1'b0;
  logic             irq_take;
  logic [VEC_W-1:0] irq_vector;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .VEC_W(VEC_W), .PERIPH_MASK(PMASK)) u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .src_evt(src_evt), .irq_ret(irq_ret),
    .irq_take(irq_take), .irq_vector(irq_vector)
  );

  // Reference model state, built from the requirements.
  logic [2:0]       m_ctrl = '0;
  logic [NSRC-1:0]  m_flag = '0, m_en = '0, m_pri = '0;
  logic             m_hi = 0, m_lo = 0, m_nest = 0, m_take = 0;
  logic [VEC_W-1:0] m_vec = '0;

  function automatic logic [NSRC-1:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {{(NSRC-3){1'b0}}, m_ctrl};
      3'd1: return m_flag;
      3'd2: return m_en;
      3'd3: return m_pri;
      3'd4: return {{(NSRC-3){1'b0}}, m_nest, m_lo, m_hi};
      default: return '0;
    endcase
  endfunction

  task automatic model_step(input logic we, input logic [2:0] wa,
                            input logic [NSRC-1:0] wd, input logic [NSRC-1:0] ev,
                            input logic rt);
    logic tk_hi, tk_lo, hq, lq;
    logic [NSRC-1:0] armed;
    armed = m_flag & m_en;
    tk_hi = 0; tk_lo = 0;
    if (!m_ctrl[0]) begin
      tk_hi = m_ctrl[1] && |(armed & (~PMASK | {NSRC{m_ctrl[2]}})) && !rt;
    end else begin
      hq = m_ctrl[1] && |(armed & m_pri);
      lq = m_ctrl[2] && |(armed & ~m_pri) && !m_hi;
      tk_hi = hq && !rt;
      tk_lo = lq && !hq && !rt;
    end
    if (we && wa == 3'd0) m_ctrl = wd[2:0];
    if (we && wa == 3'd1) m_flag = wd;
    if (we && wa == 3'd2) m_en   = wd;
    if (we && wa == 3'd3) m_pri  = wd;
    m_flag = m_flag | ev;
    if (rt) begin
      if (m_hi) begin m_hi = 0; m_nest = 0; m_ctrl[1] = 1; end
      else if (m_lo) begin m_lo = 0; m_ctrl[2] = 1; end
    end
    if (tk_hi) begin m_ctrl[1] = 0; m_nest = m_lo; m_hi = 1; m_vec = 16'h0008; end
    else if (tk_lo) begin m_ctrl[2] = 0; m_lo = 1; m_vec = 16'h0018; end
    m_take = tk_hi | tk_lo;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, step the model, cross the
  // rising edge, compare outputs at the next falling edge.
  task automatic cyc(input logic we, input logic [2:0] wa, input logic [NSRC-1:0] wd,
                     input logic [NSRC-1:0] ev, input logic rt);
    reg_wr_en = we; reg_wr_addr = wa; reg_wr_data = wd; src_evt = ev; irq_ret = rt;
    model_step(we, wa, wd, ev, rt);
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 0; src_evt = '0; irq_ret = 0;
    chk("R9 take", {31'd0, irq_take}, {31'd0, m_take});
    chk("R5 vector", {16'd0, irq_vector}, {16'd0, m_vec});
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, '0, '0, 1'b0);
  endtask

  task automatic peek(input logic [2:0] a, input string req);
    reg_rd_addr = a;
    #1;
    chk(req, {16'd0, reg_rd_data}, {16'd0, model_read(a)});
  endtask

  task automatic peek_lit(input logic [2:0] a, input logic [15:0] exp, input string req);
    reg_rd_addr = a;
    #1;
    chk(req, {16'd0, reg_rd_data}, {16'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 take", {31'd0, irq_take}, 32'd0);
    chk("R1 vector", {16'd0, irq_vector}, 32'd0);
    for (int a = 0; a < 5; a++) peek_lit(3'(a), 16'h0000, "R1 reset regs");

    // R2 flag set, collision with clearing write, clear by write
    cyc(1'b0, 3'd0, '0, 16'h0008, 1'b0);
    peek_lit(3'd1, 16'h0008, "R2 event sets flag");
    cyc(1'b1, 3'd1, 16'h0000, 16'h0008, 1'b0);
    peek_lit(3'd1, 16'h0008, "R2 event beats clear");
    cyc(1'b1, 3'd1, 16'h0000, '0, 1'b0);
    peek_lit(3'd1, 16'h0000, "R2 write clears");

    // R11 readback
    cyc(1'b1, 3'd2, 16'h0011, '0, 1'b0);
    peek_lit(3'd2, 16'h0011, "R11 enable readback");
    peek_lit(3'd6, 16'h0000, "R11 unmapped reads zero");

    // R3 compatibility: peripheral source 4 needs bit 2
    cyc(1'b1, 3'd0, 16'hFFFA, '0, 1'b0);
    peek_lit(3'd0, 16'h0002, "R11 control width");
    cyc(1'b0, 3'd0, '0, 16'h0010, 1'b0);
    idle();
    chk("R3 periph gated", {31'd0, irq_take}, 32'd0);
    cyc(1'b0, 3'd0, '0, 16'h0001, 1'b0);
    idle();
    chk("R3 compat take", {31'd0, irq_take}, 32'd1);
    chk("R3 compat vector", {16'd0, irq_vector}, 32'h0008);
    peek_lit(3'd0, 16'h0000, "R4 global enable cleared");
    idle();
    chk("R9 single pulse", {31'd0, irq_take}, 32'd0);
    peek_lit(3'd1, 16'h0011, "R2 flags kept after take");
    cyc(1'b1, 3'd1, 16'h0000, '0, 1'b0);
    cyc(1'b0, 3'd0, '0, '0, 1'b1);
    peek_lit(3'd0, 16'h0002, "R4 return restores enable");
    peek_lit(3'd4, 16'h0000, "R4 handler closed");

    // R5/R6 priority mode: src1 high, src0 low, both at once
    cyc(1'b1, 3'd3, 16'h0002, '0, 1'b0);
    cyc(1'b1, 3'd2, 16'h0003, '0, 1'b0);
    cyc(1'b1, 3'd0, 16'h0007, 16'h0003, 1'b0);
    idle();
    chk("R6 high first", {16'd0, irq_vector}, 32'h0008);
    chk("R6 take", {31'd0, irq_take}, 32'd1);
    peek_lit(3'd4, 16'h0001, "R5 high active");
    // low is eligible but blocked by the running high handler
    idle();
    chk("R7 low blocked", {31'd0, irq_take}, 32'd0);
    cyc(1'b1, 3'd1, 16'h0001, '0, 1'b0);
    cyc(1'b0, 3'd0, '0, '0, 1'b1);
    idle();
    chk("R5 low take", {16'd0, irq_vector}, 32'h0018);
    peek_lit(3'd4, 16'h0002, "R5 low active");
    peek_lit(3'd0, 16'h0003, "R5 low enable cleared");
    // R7 preemption
    cyc(1'b0, 3'd0, '0, 16'h0002, 1'b0);
    idle();
    chk("R7 preempt vector", {16'd0, irq_vector}, 32'h0008);
    peek_lit(3'd4, 16'h0007, "R7 nested status");
    cyc(1'b1, 3'd0, 16'h0005, '0, 1'b0);
    idle(); idle();
    chk("R7 low blocked with enable", {31'd0, irq_take}, 32'd0);
    cyc(1'b1, 3'd0, 16'h0001, '0, 1'b0);
    cyc(1'b1, 3'd1, 16'h0000, '0, 1'b0);
    // R8 nested returns
    cyc(1'b0, 3'd0, '0, '0, 1'b1);
    peek_lit(3'd4, 16'h0002, "R8 low still active");
    peek_lit(3'd0, 16'h0003, "R8 high enable back");
    cyc(1'b0, 3'd0, '0, '0, 1'b1);
    peek_lit(3'd4, 16'h0000, "R8 all closed");
    peek_lit(3'd0, 16'h0007, "R8 low enable back");
    // R10 stray return
    cyc(1'b0, 3'd0, '0, '0, 1'b1);
    peek_lit(3'd0, 16'h0007, "R10 control unchanged");
    peek_lit(3'd4, 16'h0000, "R10 status unchanged");

    // Constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      logic we, rt;
      logic [2:0] wa;
      logic [NSRC-1:0] wd, ev;
      logic [2:0] ra;
      string tag;
      we = ($urandom % 6) == 0;
      wa = 3'($urandom % 4);
      wd = NSRC'($urandom);
      if (we && wa == 3'd1 && ($urandom % 2)) wd = '0;
      ev = (($urandom % 4) == 0) ? NSRC'($urandom & $urandom & $urandom) : '0;
      rt = ($urandom % 7) == 0;
      cyc(we, wa, wd, ev, rt);
      ra = 3'($urandom % 8);
      case (ra)
        3'd0: tag = "R4 control";
        3'd1: tag = "R2 flags";
        3'd4: tag = "R7 status";
        default: tag = "R11 regs";
      endcase
      peek(ra, tag);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule